// File: doc/BRIEF.md
# Reset and Boot Sequencing Controller

This block steers a small processor core out of reset. It separates a cold start from a warm reset. After power-on it keeps the core in reset until a lock-wait counter on the input clock has run out, so the clock source has time to settle. A warm reset comes from the pin once the core is running. It adds no wait, but the pin must stay low for a minimum number of cycles before the reset is accepted. While reset is in force, the block drives the clear and mask strobes that put the stack pointers, the interrupt mask and the mode status register into their initial state.

When reset ends, the block chooses the next step from two inputs: the memory-map mode pin and any pending bus request. It can start a boot load, wait for the bus request to drop, or go straight to the first instruction fetch at address zero. The block also drives a clock output that follows the input clock. Software can switch that output off through one bit of a memory-mapped control word.

Top module: `rstseq_ctrl`

## Requirements
- R1: After `por_n` rises, `core_rst`, every bit of `stk_clr` and `mode_stat_clr` stay high for at least LOCK_CYCLES (default 2000) rising edges of `clk_in`, whatever the level of `rst_pin_n`.
- R2: Outside the cold window, a warm reset takes effect 2+MIN_PULSE edges after `rst_pin_n` falls, provided the pin stays low across MIN_PULSE (default 4) edges. Release takes effect on the third edge after the pin rises.
- R3: Outside the cold window, a low pulse on `rst_pin_n` that spans fewer than MIN_PULSE edges has no effect on any output, and the sequence state carries on unchanged.
- R4: `stk_clr` (all ones), `irq_mask_all` and `mode_stat_clr` are high exactly while the block is in the cold wait or in an accepted reset. They are low in every other state.
- R5: At release with `bus_req` low, `mmap_mode`=0 starts a boot load (`boot_active` high) and `mmap_mode`=1 goes directly to the first fetch.
- R6: If `bus_req` is high at release, the block holds, with `core_rst` high, `boot_active` low and the reset strobes low, until `bus_req` drops. It then re-evaluates `mmap_mode`.
- R7: `boot_done` ends a boot load. On entry to run, `fetch_start` is high for exactly one cycle, `fetch_addr` is 0 and `core_rst` is low.
- R8: A write to address 0x3FF3 sets the clock-disable bit from data bit 14. While that bit is 1, `clk_out` stays low. While it is 0, `clk_out` follows `clk_in`. Writes to other addresses change nothing.
- R9: The clock-disable bit is 0 after power-on and after every accepted warm reset.
- R10: If a warm reset is accepted on the same edge that `boot_done` arrives, the reset wins. The block enters reset and `fetch_start` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_n | input | 1 | Reset pin, active low, asynchronous |
| mmap_mode | input | 1 | Memory-map mode; 0 selects boot loading |
| bus_req | input | 1 | External bus request |
| boot_done | input | 1 | Boot loader finished |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_wr_addr | input | ADDR_W | Write address |
| cfg_wr_data | input | DATA_W | Write data |
| core_rst | output | 1 | Core held (high until run) |
| stk_clr | output | NUM_STACKS | Set stack pointers to empty |
| irq_mask_all | output | 1 | Mask all interrupts |
| mode_stat_clr | output | 1 | Clear mode status register |
| boot_active | output | 1 | Boot load in progress |
| fetch_start | output | 1 | One-cycle first-fetch pulse |
| fetch_addr | output | PC_W | First fetch address (zero) |
| clk_out | output | 1 | Gated clock output |

## Verification
Acceptance of a warm reset and completion of a boot load can happen on the same rising edge. One would move the sequence to reset and the other would move it to the first fetch. The bench lowers the pin during a boot load and counts edges until the acceptance edge, then raises `boot_done` for that single edge only. It judges the result by `core_rst` and `irq_mask_all` being high, `boot_active` low, and no `fetch_start` pulse on that edge or the next one.

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl #(
  parameter int LOCK_CYCLES = 2000,
  parameter int MIN_PULSE   = 4,
  parameter int NUM_STACKS  = 4,
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 16,
  parameter int PC_W        = 14,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 14'h3FF3,
  parameter int CLKDIS_BIT  = 14
) (
  input  logic                  clk_in,
  input  logic                  por_n,
  input  logic                  rst_pin_n,
  input  logic                  mmap_mode,
  input  logic                  bus_req,
  input  logic                  boot_done,
  input  logic                  cfg_wr_en,
  input  logic [ADDR_W-1:0]     cfg_wr_addr,
  input  logic [DATA_W-1:0]     cfg_wr_data,
  output logic                  core_rst,
  output logic [NUM_STACKS-1:0] stk_clr,
  output logic                  irq_mask_all,
  output logic                  mode_stat_clr,
  output logic                  boot_active,
  output logic                  fetch_start,
  output logic [PC_W-1:0]       fetch_addr,
  output logic                  clk_out
);
  localparam int LOCK_W = $clog2(LOCK_CYCLES + 1);
  localparam int PW_W   = $clog2(MIN_PULSE + 1);
  localparam logic [LOCK_W-1:0] LOCK_LAST = LOCK_W'(LOCK_CYCLES - 1);
  localparam logic [PW_W-1:0]   PW_LAST   = PW_W'(MIN_PULSE - 1);

  typedef enum logic [2:0] {COLD_WAIT, IN_RESET, BUS_HOLD, BOOTING, RUN} seq_t;

  seq_t              state, nxt;
  logic [1:0]        pin_sync;
  logic [LOCK_W-1:0] lock_cnt;
  logic [PW_W-1:0]   low_cnt;
  logic              clkdis_q, clk_en_lo, fetch_q;
  logic              rst_seen, lock_done, warm_hit, in_rst;
  seq_t              after_rel;
  logic              cfg_data_unused;

  assign cfg_data_unused = ^cfg_wr_data;

  assign rst_seen  = ~pin_sync[1];
  assign lock_done = (lock_cnt == LOCK_LAST);
  assign warm_hit  = rst_seen && (low_cnt == PW_LAST) && (state != COLD_WAIT);
  assign after_rel = mmap_mode ? RUN : BOOTING;
  assign in_rst    = (state == COLD_WAIT) || (state == IN_RESET);

  always_ff @(posedge clk_in or negedge por_n)
    if (!por_n) pin_sync <= 2'b00;
    else        pin_sync <= {pin_sync[0], rst_pin_n};

  always_ff @(posedge clk_in or negedge por_n)
    if (!por_n)                              lock_cnt <= '0;
    else if (state == COLD_WAIT && !lock_done) lock_cnt <= lock_cnt + 1'b1;

  always_ff @(posedge clk_in or negedge por_n)
    if (!por_n)                         low_cnt <= '0;
    else if (!rst_seen)                 low_cnt <= '0;
    else if (low_cnt != PW_LAST)        low_cnt <= low_cnt + 1'b1;

  always_comb begin
    nxt = state;
    case (state)
      COLD_WAIT: if (lock_done) nxt = IN_RESET;
      IN_RESET:  if (!rst_seen) nxt = bus_req ? BUS_HOLD : after_rel;
      BUS_HOLD:  if (!bus_req)  nxt = after_rel;
      BOOTING:   if (boot_done) nxt = RUN;
      default:   nxt = state;
    endcase
    if (warm_hit) nxt = IN_RESET;
  end

  always_ff @(posedge clk_in or negedge por_n)
    if (!por_n) begin
      state   <= COLD_WAIT;
      fetch_q <= 1'b0;
    end else begin
      state   <= nxt;
      fetch_q <= (nxt == RUN) && (state != RUN);
    end

  always_ff @(posedge clk_in or negedge por_n)
    if (!por_n)      clkdis_q <= 1'b0;
    else if (in_rst) clkdis_q <= 1'b0;
    else if (cfg_wr_en && cfg_wr_addr == CTRL_ADDR)
                     clkdis_q <= cfg_wr_data[CLKDIS_BIT];

  always_ff @(negedge clk_in or negedge por_n)
    if (!por_n) clk_en_lo <= 1'b1;
    else        clk_en_lo <= ~clkdis_q;

  assign clk_out       = clk_in & clk_en_lo;
  assign core_rst      = (state != RUN);
  assign stk_clr       = {NUM_STACKS{in_rst}};
  assign irq_mask_all  = in_rst;
  assign mode_stat_clr = in_rst;
  assign boot_active   = (state == BOOTING);
  assign fetch_start   = fetch_q;
  assign fetch_addr    = '0;

  AST_LOCK_HOLD: assert property (@(posedge clk_in) disable iff (!por_n)
    (state == COLD_WAIT && !lock_done) |=> (state == COLD_WAIT)); // R1
  AST_SHORT_IGNORED: assert property (@(posedge clk_in) disable iff (!por_n)
    (state == RUN && low_cnt != PW_LAST) |=> (state == RUN)); // R3
  AST_STROBES_OFF: assert property (@(posedge clk_in) disable iff (!por_n)
    !core_rst |-> (!irq_mask_all && !mode_stat_clr)); // R4
  AST_NO_EARLY_BOOT: assert property (@(posedge clk_in) disable iff (!por_n)
    (state == IN_RESET && !rst_seen && (bus_req || mmap_mode)) |=> !boot_active); // R5
  AST_HOLD_WAIT: assert property (@(posedge clk_in) disable iff (!por_n)
    (state == BUS_HOLD && bus_req && !rst_seen) |=> (state == BUS_HOLD)); // R6
  AST_FETCH_ONE: assert property (@(posedge clk_in) disable iff (!por_n)
    fetch_start |=> !fetch_start); // R7
  AST_FETCH_RUN: assert property (@(posedge clk_in) disable iff (!por_n)
    fetch_start |-> !core_rst); // R7
  AST_RESET_WINS: assert property (@(posedge clk_in) disable iff (!por_n)
    (boot_active && boot_done && warm_hit) |=> (core_rst && !fetch_start)); // R10
endmodule

// File: tb/sim_rstseq_ctrl.sv
module sim_rstseq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK   = 2000;
  localparam int MIN_PW = 4;

  logic clk = 1'b0, por_n = 1'b0, rst_pin_n = 1'b0, mmap_mode = 1'b0;
  logic bus_req = 1'b0, boot_done = 1'b0, cfg_wr_en = 1'b0;
  logic [13:0] cfg_wr_addr = '0;
  logic [15:0] cfg_wr_data = '0;
  logic core_rst, irq_mask_all, mode_stat_clr, boot_active, fetch_start, clk_out;
  logic [3:0]  stk_clr;
  logic [13:0] fetch_addr;
  int n_checks = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstseq_ctrl #(.LOCK_CYCLES(LOCK), .MIN_PULSE(MIN_PW)) u0 (
    .clk_in(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .mmap_mode(mmap_mode),
    .bus_req(bus_req), .boot_done(boot_done), .cfg_wr_en(cfg_wr_en),
    .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data), .core_rst(core_rst),
    .stk_clr(stk_clr), .irq_mask_all(irq_mask_all), .mode_stat_clr(mode_stat_clr),
    .boot_active(boot_active), .fetch_start(fetch_start), .fetch_addr(fetch_addr),
    .clk_out(clk_out));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic get_clk(output logic v);
    @(posedge clk);
    #(CLK_PERIOD/4);
    v = clk_out;
    @(negedge clk);
  endtask

  task automatic wr(input logic [13:0] a, input logic [15:0] d);
    cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
    tick();
    cfg_wr_en = 1'b0;
  endtask

  task automatic warm_reset(input bit mm, input bit br);
    mmap_mode = mm; bus_req = br;
    rst_pin_n = 1'b0;
    repeat (MIN_PW + 3) tick();
    rst_pin_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic t_cold();
    int bad = 0;
    check(core_rst && stk_clr == 4'hF, "R4 reset state", int'(core_rst), 1);
    por_n = 1'b1;
    for (int i = 0; i < LOCK; i++) begin
      if (i == 50) rst_pin_n = 1'b1;
      tick();
      if (!core_rst || !mode_stat_clr || stk_clr != 4'hF) bad++;
    end
    check(bad == 0, "R1 held through lock wait", bad, 0);
    check(irq_mask_all == 1'b1, "R4 mask at end of wait", int'(irq_mask_all), 1);
    tick();
    check(boot_active == 1'b1, "R5 boot after cold release", int'(boot_active), 1);
    check(irq_mask_all == 1'b0 && stk_clr == 4'h0, "R4 strobes off", int'(stk_clr), 0);
    check(core_rst == 1'b1, "R7 core held while booting", int'(core_rst), 1);
  endtask

  task automatic t_short();
    int bad = 0;
    rst_pin_n = 1'b0;
    repeat (MIN_PW - 1) tick();
    rst_pin_n = 1'b1;
    repeat (10) begin
      tick();
      if (!boot_active || irq_mask_all || fetch_start) bad++;
    end
    check(bad == 0, "R3 short pulse ignored", bad, 0);
  endtask

  task automatic t_boot_finish();
    boot_done = 1'b1;
    tick();
    boot_done = 1'b0;
    check(fetch_start == 1'b1, "R7 fetch pulse", int'(fetch_start), 1);
    check(core_rst == 1'b0 && fetch_addr == 14'd0, "R7 run at address 0", int'(fetch_addr), 0);
    tick();
    check(fetch_start == 1'b0, "R7 pulse one cycle", int'(fetch_start), 0);
  endtask

  task automatic t_clkout();
    logic v;
    get_clk(v); check(v == 1'b1, "R9 enabled after power-on", int'(v), 1);
    wr(14'h3FF2, 16'h4000);
    get_clk(v); check(v == 1'b1, "R8 other address ignored", int'(v), 1);
    wr(14'h3FF3, 16'h4000);
    get_clk(v); check(v == 1'b0, "R8 disabled", int'(v), 0);
    get_clk(v); check(v == 1'b0, "R8 stays disabled", int'(v), 0);
    wr(14'h3FF3, 16'hBFFF);
    get_clk(v); check(v == 1'b1, "R8 re-enabled", int'(v), 1);
    wr(14'h3FF3, 16'h4000);
    get_clk(v); check(v == 1'b0, "R8 disabled again", int'(v), 0);
    warm_reset(1'b1, 1'b0);
    get_clk(v); check(v == 1'b1, "R9 enabled after warm reset", int'(v), 1);
  endtask

  task automatic t_warm();
    mmap_mode = 1'b1;
    rst_pin_n = 1'b0;
    repeat (MIN_PW + 1) tick();
    check(core_rst == 1'b0, "R2 not accepted early", int'(core_rst), 0);
    tick();
    check(core_rst && irq_mask_all && stk_clr == 4'hF, "R2 accepted R4 strobes", int'(core_rst), 1);
    repeat (3) tick();
    rst_pin_n = 1'b1;
    repeat (2) tick();
    check(core_rst == 1'b1, "R2 release latency", int'(core_rst), 1);
    tick();
    check(fetch_start && !boot_active, "R5 direct fetch with mode 1", int'(fetch_start), 1);
  endtask

  task automatic t_bus_hold();
    int bad = 0;
    warm_reset(1'b0, 1'b1);
    check(core_rst && !boot_active && !irq_mask_all, "R6 hold state", int'(boot_active), 0);
    repeat (4) begin
      tick();
      if (!core_rst || boot_active || irq_mask_all || fetch_start) bad++;
    end
    check(bad == 0, "R6 holds while requested", bad, 0);
    mmap_mode = 1'b1;
    bus_req = 1'b0;
    tick();
    check(fetch_start && !boot_active, "R6 re-evaluated mode", int'(fetch_start), 1);
    warm_reset(1'b0, 1'b1);
    bus_req = 1'b0;
    tick();
    check(boot_active == 1'b1, "R6 boot after drop", int'(boot_active), 1);
  endtask

  task automatic t_collide();
    rst_pin_n = 1'b0;
    repeat (MIN_PW + 1) tick();
    boot_done = 1'b1;
    tick();
    boot_done = 1'b0;
    check(core_rst && irq_mask_all && !boot_active, "R10 reset wins", int'(irq_mask_all), 1);
    check(fetch_start == 1'b0, "R10 no fetch pulse", int'(fetch_start), 0);
    tick();
    check(fetch_start == 1'b0, "R10 no late fetch pulse", int'(fetch_start), 0);
    mmap_mode = 1'b1;
    rst_pin_n = 1'b1;
    repeat (3) tick();
    check(fetch_start == 1'b1, "R2 release after collision", int'(fetch_start), 1);
  endtask

  initial begin
    repeat (3) tick();
    t_cold();
    t_short();
    t_boot_finish();
    t_clkout();
    t_warm();
    t_bus_hold();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule